// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs the acquire-then-convert loop around an analog-to-digital converter. Each conversion is preceded by a sampling phase. Sampling begins either on a software request or automatically whenever the converter is free. It ends on one of three selectable events: a software convert request, an external pulse or a timer compare pulse. The converter is represented by a behavioural stub. The stub captures the selected slice of a flat analog input vector and reports it after a fixed latency.

For each conversion the block picks the channel in one of three ways. It can step through the set bits of a channel mask. It can use a fixed primary channel. It can interleave either of those with a fixed alternate channel. Results fill a result buffer from its first location. After a programmed number of conversions a sticky interrupt flag is raised and the sequence starts over. Optionally the buffer works as two halves, and the halves swap after every interrupt so that software can read one half while the other fills.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset, `sampling`, `converting`, `convDone`, `irqFlag` and `halfSel` are all 0, and `sampling` and `converting` are never 1 together.
- R2: With `autoSample`=0, sampling starts only after a `sampleReq` pulse and is visible the following cycle. After a conversion completes, the block stays idle until another `sampleReq`.
- R3: With `autoSample`=1, sampling starts by itself once enabled, and `sampling` is already 1 in the cycle where `convDone` pulses.
- R4: `trigSel` picks the event that ends sampling: 0 or 3 selects `convReq`, 1 selects `extTrig`, and 2 selects `timerTrig`. Pulses on the unselected sources leave the block sampling.
- R5: When sampling ends, the stub captures `anaIn[ch*RES_W +: RES_W]` for the chosen channel `ch`. The result is written CONV_LAT cycles later. `convDone` is a one-cycle pulse in the cycle after the write, with the channel on `convChan`.
- R6: With `scanEn`=1 the primary channel walks upward through the set bits of `scanMask` (bit n = channel n) and wraps from the highest set bit to the lowest. An all-zero mask converts channel 0. With `scanEn`=0 the primary channel is `priChan`.
- R7: With `altEn`=1, conversions alternate between the primary channel and `altChan`, starting with the primary. Only the primary conversions advance the scan.
- R8: Results go to consecutive buffer locations starting at 0. `irqFlag` rises with the `convDone` of conversion number `countSel`+1.
- R9: The conversion that raises the interrupt resets the buffer index, the scan position and the alternate phase. The next result goes to the first location of the active region.
- R10: With `dualBuf`=1, only `countSel[2:0]` counts (1 to 8 conversions). Writes start at location 0 when `halfSel`=0 and at location 8 when `halfSel`=1, and `halfSel` toggles with each interrupt.
- R11: `irqFlag` stays 1 until an `irqClr` pulse clears it. A new interrupt in the same cycle wins over the clear.
- R12: Driving `enable` low aborts sampling or conversion within one cycle without a `convDone`. It also resets the scan position, the buffer index, the alternate phase and `halfSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; low aborts and clears the sequence |
| autoSample | input | 1 | 1: restart sampling automatically after each conversion |
| sampleReq | input | 1 | Software sample request pulse (manual mode) |
| convReq | input | 1 | Software end-of-sampling pulse |
| trigSel | input | 2 | End-of-sampling source: 0/3 software, 1 external, 2 timer |
| extTrig | input | 1 | External trigger pulse |
| timerTrig | input | 1 | Timer compare pulse |
| scanEn | input | 1 | Scan the primary channel through `scanMask` |
| altEn | input | 1 | Interleave the alternate channel |
| scanMask | input | NUM_CH | Channel select mask for scanning |
| priChan | input | CH_W | Primary channel when scanning is off |
| altChan | input | CH_W | Alternate channel |
| countSel | input | BUF_AW | Conversions per interrupt minus one |
| dualBuf | input | 1 | Split the buffer into two halves |
| irqClr | input | 1 | Write-one-to-clear pulse for `irqFlag` |
| anaIn | input | NUM_CH*RES_W | Flat vector of analog input values seen by the stub |
| rdAddr | input | BUF_AW | Result buffer read address |
| rdData | output | RES_W | Result at `rdAddr` |
| sampling | output | 1 | Sampling phase active |
| converting | output | 1 | Conversion in progress |
| convDone | output | 1 | One-cycle pulse per completed conversion |
| convChan | output | CH_W | Channel of the last conversion |
| irqFlag | output | 1 | Sticky interrupt flag |
| halfSel | output | 1 | Buffer half currently being filled |

## Verification
A scan position that is off by one shows on `convChan` at the very next `convDone`, and the stale result then appears at the buffer location the bench reads. If the buffer index or the half select goes wrong, the result lands at an unexpected address, and the interrupt arrives early or late by whole conversions. The bench catches this at the next interrupt boundary, at most eight or sixteen conversions later. A sequencer that leaks through an abort or an unselected trigger changes `sampling` or `converting` within a cycle or two of the stimulus. A conversion that survives an abort produces a stray `convDone` within CONV_LAT cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } seqState_t;

  typedef enum logic [1:0] {
    TRIG_SOFT     = 2'd0,
    TRIG_EXT      = 2'd1,
    TRIG_TIMER    = 2'd2,
    TRIG_SOFT_ALT = 2'd3
  } trigSrc_t;

  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic clear;      // module disabled: drop pointers
    logic convStart;  // sampling ends, channel latched
    logic commit;     // converter result is written
  } seqStrobe_t;
endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int NUM_CH   = 16,
  parameter int RES_W    = 10,
  parameter int CONV_LAT = 4,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int CNT_W   = $clog2(CONV_LAT + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    abort,
  input  logic [CH_W-1:0]         chan,
  input  logic [NUM_CH*RES_W-1:0] anaIn,
  output logic                    done,
  output logic [RES_W-1:0]        data
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      data <= '0;
    end else if (abort) begin
      cnt <= '0;
    end else if (start) begin
      cnt  <= CNT_W'(CONV_LAT);
      data <= anaIn[int'(chan)*RES_W +: RES_W];
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       autoSample,
  input  logic       sampleReq,
  input  logic       convReq,
  input  logic [1:0] trigSel,
  input  logic       extTrig,
  input  logic       timerTrig,
  input  logic       stubDone,
  output seqStrobe_t strobe,
  output logic       sampling,
  output logic       converting
);
  seqState_t state, stateNext;
  logic endHit;

  always_comb begin
    case (trigSrc_t'(trigSel))
      TRIG_EXT:   endHit = extTrig;
      TRIG_TIMER: endHit = timerTrig;
      default:    endHit = convReq;
    endcase
  end

  always_comb begin
    stateNext        = state;
    strobe           = '0;
    strobe.clear     = !enable;
    if (!enable) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:
          if (autoSample || sampleReq) stateNext = ST_SAMPLE;
        ST_SAMPLE:
          if (endHit) begin
            strobe.convStart = 1'b1;
            stateNext        = ST_CONVERT;
          end
        ST_CONVERT:
          if (stubDone) begin
            strobe.commit = 1'b1;
            stateNext     = autoSample ? ST_SAMPLE : ST_IDLE;
          end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign sampling   = (state == ST_SAMPLE);
  assign converting = (state == ST_CONVERT);
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int RES_W     = 10,
  parameter int BUF_DEPTH = 16,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int BUF_AW   = $clog2(BUF_DEPTH),
  localparam int HALF     = BUF_DEPTH / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              scanEn,
  input  logic              altEn,
  input  logic [NUM_CH-1:0] scanMask,
  input  logic [CH_W-1:0]   priChan,
  input  logic [CH_W-1:0]   altChan,
  input  logic [BUF_AW-1:0] countSel,
  input  logic              dualBuf,
  input  logic              irqClr,
  input  logic [RES_W-1:0]  convData,
  input  logic [BUF_AW-1:0] rdAddr,
  output logic [CH_W-1:0]   curChan,
  output logic [RES_W-1:0]  rdData,
  output logic              irqFlag,
  output logic              convDone,
  output logic [CH_W-1:0]   convChan,
  output logic              halfSel
);
  logic [CH_W-1:0]   scanPtr, scanPick, chanQ, nextPtr;
  logic              altPhase, altQ, half, irqQ, doneQ, atLast;
  logic [BUF_AW-1:0] bufPtr, lastIdx, wrAddr;
  logic [RES_W-1:0]  resultMem [BUF_DEPTH];

  // first selected channel at or above the scan position, channel 0 if none
  function automatic logic [CH_W-1:0] pickScan(input logic [NUM_CH-1:0] m,
                                               input logic [CH_W-1:0] p);
    logic [CH_W-1:0] r;
    logic            found;
    logic [CH_W-1:0] c;
    r     = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      c = CH_W'((int'(p) + i) % NUM_CH);
      if (!found && m[c]) begin
        r     = c;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  assign scanPick = pickScan(scanMask, scanPtr);
  assign curChan  = (altEn && altPhase) ? altChan : (scanEn ? scanPick : priChan);
  assign nextPtr  = (chanQ == CH_W'(NUM_CH - 1)) ? '0 : chanQ + 1'b1;
  assign lastIdx  = dualBuf ? (countSel & BUF_AW'(HALF - 1)) : countSel;
  assign atLast   = (bufPtr == lastIdx);
  assign wrAddr   = (dualBuf && half) ? bufPtr + BUF_AW'(HALF) : bufPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanPtr  <= '0;
      altPhase <= 1'b0;
      bufPtr   <= '0;
      half     <= 1'b0;
      irqQ     <= 1'b0;
      doneQ    <= 1'b0;
      chanQ    <= '0;
      altQ     <= 1'b0;
    end else begin
      doneQ <= strobe.commit;
      if (irqClr) irqQ <= 1'b0;
      if (strobe.clear) begin
        scanPtr  <= '0;
        altPhase <= 1'b0;
        bufPtr   <= '0;
        half     <= 1'b0;
      end else begin
        if (strobe.convStart) begin
          chanQ <= curChan;
          altQ  <= altEn && altPhase;
        end
        if (strobe.commit) begin
          if (atLast) begin
            bufPtr   <= '0;
            scanPtr  <= '0;
            altPhase <= 1'b0;
            irqQ     <= 1'b1;
            half     <= dualBuf ? !half : 1'b0;
          end else begin
            bufPtr   <= bufPtr + 1'b1;
            altPhase <= altEn && !altQ;
            if (scanEn && !altQ) scanPtr <= nextPtr;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commit) resultMem[wrAddr] <= convData;
  end

  assign rdData   = resultMem[rdAddr];
  assign irqFlag  = irqQ;
  assign convDone = doneQ;
  assign convChan = chanQ;
  assign halfSel  = half;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int RES_W     = 10,
  parameter int BUF_DEPTH = 16,
  parameter int CONV_LAT  = 4,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    autoSample,
  input  logic                    sampleReq,
  input  logic                    convReq,
  input  logic [1:0]              trigSel,
  input  logic                    extTrig,
  input  logic                    timerTrig,
  input  logic                    scanEn,
  input  logic                    altEn,
  input  logic [NUM_CH-1:0]       scanMask,
  input  logic [CH_W-1:0]         priChan,
  input  logic [CH_W-1:0]         altChan,
  input  logic [BUF_AW-1:0]       countSel,
  input  logic                    dualBuf,
  input  logic                    irqClr,
  input  logic [NUM_CH*RES_W-1:0] anaIn,
  input  logic [BUF_AW-1:0]       rdAddr,
  output logic [RES_W-1:0]        rdData,
  output logic                    sampling,
  output logic                    converting,
  output logic                    convDone,
  output logic [CH_W-1:0]         convChan,
  output logic                    irqFlag,
  output logic                    halfSel
);
  seqStrobe_t       strobe;
  logic             stubDone;
  logic [RES_W-1:0] stubData;
  logic [CH_W-1:0]  curChan;

  adc_seq_fsm u_fsm (
    .clk(clk), .rstN(rstN), .enable(enable), .autoSample(autoSample),
    .sampleReq(sampleReq), .convReq(convReq), .trigSel(trigSel),
    .extTrig(extTrig), .timerTrig(timerTrig), .stubDone(stubDone),
    .strobe(strobe), .sampling(sampling), .converting(converting)
  );

  adc_conv_stub #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CONV_LAT(CONV_LAT)) u_stub (
    .clk(clk), .rstN(rstN), .start(strobe.convStart), .abort(strobe.clear),
    .chan(curChan), .anaIn(anaIn), .done(stubDone), .data(stubData)
  );

  adc_seq_datapath #(.NUM_CH(NUM_CH), .RES_W(RES_W), .BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanEn(scanEn), .altEn(altEn),
    .scanMask(scanMask), .priChan(priChan), .altChan(altChan),
    .countSel(countSel), .dualBuf(dualBuf), .irqClr(irqClr),
    .convData(stubData), .rdAddr(rdAddr), .curChan(curChan), .rdData(rdData),
    .irqFlag(irqFlag), .convDone(convDone), .convChan(convChan), .halfSel(halfSel)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              autoSample,
  input logic              scanEn,
  input logic              altEn,
  input logic [NUM_CH-1:0] scanMask,
  input logic [CH_W-1:0]   convChan,
  input logic              convDone,
  input logic              sampling,
  input logic              converting,
  input logic              irqFlag,
  input logic              halfSel
);
  p_phase_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(sampling && converting));

  p_manual_halt_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(converting) && !converting && !$past(autoSample)) |-> !sampling);

  p_auto_resample_r3: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && $past(autoSample)) |-> sampling);

  p_done_after_conv_r5: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> $past(converting));

  p_scan_member_r6: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && scanEn && !altEn && (scanMask != '0)) |-> scanMask[convChan]);

  p_irq_on_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> convDone);

  p_half_on_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    (halfSel != $past(halfSel)) |-> (convDone || !$past(enable)));

  p_off_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sampling && !converting && !convDone));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (.*);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  localparam int NUM_CH = 16;
  localparam int RES_W  = 10;
  localparam int DEPTH  = 16;
  localparam int LAT    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 0, autoSample = 0, sampleReq = 0, convReq = 0;
  logic [1:0] trigSel = 0;
  logic extTrig = 0, timerTrig = 0, scanEn = 0, altEn = 0;
  logic [NUM_CH-1:0] scanMask = '0;
  logic [3:0] priChan = 0, altChan = 0, countSel = 0, rdAddr = 0;
  logic dualBuf = 0, irqClr = 0;
  logic [NUM_CH*RES_W-1:0] anaIn = '0;
  logic [RES_W-1:0] rdData;
  logic sampling, converting, convDone, irqFlag, halfSel;
  logic [3:0] convChan;

  int errors = 0;
  int checks = 0;
  int salt = 0;
  bit autoMode = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W), .BUF_DEPTH(DEPTH), .CONV_LAT(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .autoSample(autoSample),
    .sampleReq(sampleReq), .convReq(convReq), .trigSel(trigSel),
    .extTrig(extTrig), .timerTrig(timerTrig), .scanEn(scanEn), .altEn(altEn),
    .scanMask(scanMask), .priChan(priChan), .altChan(altChan),
    .countSel(countSel), .dualBuf(dualBuf), .irqClr(irqClr), .anaIn(anaIn),
    .rdAddr(rdAddr), .rdData(rdData), .sampling(sampling),
    .converting(converting), .convDone(convDone), .convChan(convChan),
    .irqFlag(irqFlag), .halfSel(halfSel)
  );

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int aval(input int ch);
    return (ch * 37 + salt) & 10'h3FF;
  endfunction

  task automatic setAna(input int s);
    salt = s;
    for (int ch = 0; ch < NUM_CH; ch++) anaIn[ch*RES_W +: RES_W] = RES_W'(aval(ch));
  endtask

  // 0 convReq, 1 extTrig, 2 timerTrig, 3 sampleReq, 4 irqClr
  task automatic pulseSig(input int which);
    @(negedge clk);
    case (which)
      0: convReq = 1; 1: extTrig = 1; 2: timerTrig = 1; 3: sampleReq = 1; default: irqClr = 1;
    endcase
    @(negedge clk);
    convReq = 0; extTrig = 0; timerTrig = 0; sampleReq = 0; irqClr = 0;
  endtask

  task automatic configure(input bit au, input int trig, input bit sc, input bit al,
                           input logic [15:0] mask, input int pri, input int alc,
                           input int cnt, input bit dual);
    @(negedge clk);
    enable = 0;
    autoMode = au; autoSample = au; trigSel = 2'(trig); scanEn = sc; altEn = al;
    scanMask = mask; priChan = 4'(pri); altChan = 4'(alc); countSel = 4'(cnt); dualBuf = dual;
    pulseSig(4);
    enable = 1;
  endtask

  task automatic doConv(input int trig, input int expCh, input int expAddr,
                        input bit expIrq, input string req, output int lat);
    int n;
    if (!autoMode && !sampling) pulseSig(3);
    n = 0;
    while (!sampling && n < 40) begin @(negedge clk); n++; end
    chkEq(req, "sampling before trigger", int'(sampling), 1);
    pulseSig(trig);
    lat = 1;
    while (!convDone && lat < 40) begin @(negedge clk); lat++; end
    chkEq(req, "convDone seen", int'(convDone), 1);
    chkEq(req, "convChan", int'(convChan), expCh);
    chkEq(req, "irqFlag at done", int'(irqFlag), int'(expIrq));
    if (autoMode) chkEq("R3", "resampling at done", int'(sampling), 1);
    rdAddr = 4'(expAddr);
    #1;
    chkEq(req, $sformatf("rdData[%0d]", expAddr), int'(rdData), aval(expCh));
  endtask

  task automatic tReset();
    chkEq("R1", "sampling after reset", int'(sampling), 0);
    chkEq("R1", "converting after reset", int'(converting), 0);
    chkEq("R1", "convDone after reset", int'(convDone), 0);
    chkEq("R1", "irqFlag after reset", int'(irqFlag), 0);
    chkEq("R1", "halfSel after reset", int'(halfSel), 0);
  endtask

  task automatic tManual();
    int lat;
    setAna(3);
    configure(0, 0, 0, 0, 16'h0000, 5, 0, 0, 0);
    repeat (3) @(negedge clk);
    chkEq("R2", "no sampling without request", int'(sampling), 0);
    pulseSig(3);
    chkEq("R2", "sampling after sampleReq", int'(sampling), 1);
    pulseSig(1);
    pulseSig(2);
    @(negedge clk);
    chkEq("R4", "unselected triggers ignored", int'(sampling), 1);
    chkEq("R4", "no conversion from unselected", int'(converting), 0);
    doConv(0, 5, 0, 1, "R6", lat);
    chkEq("R5", "conversion latency", lat, LAT + 1);
    repeat (4) @(negedge clk);
    chkEq("R2", "idle after manual conversion", int'(sampling), 0);
    chkEq("R11", "irqFlag sticky", int'(irqFlag), 1);
    pulseSig(4);
    chkEq("R11", "irqFlag cleared", int'(irqFlag), 0);
    trigSel = 2'd3;
    doConv(0, 5, 0, 1, "R4", lat);
  endtask

  task automatic tScanAuto();
    int lat;
    setAna(11);
    configure(1, 2, 1, 0, 16'h8420, 0, 0, 3, 0);
    pulseSig(1);
    pulseSig(0);
    chkEq("R4", "ext and soft ignored in timer mode", int'(sampling), 1);
    doConv(2, 5, 0, 0, "R8", lat);
    doConv(2, 10, 1, 0, "R8", lat);
    doConv(2, 15, 2, 0, "R8", lat);
    doConv(2, 5, 3, 1, "R8", lat);
    configure(1, 2, 1, 0, 16'h001C, 0, 0, 1, 0);
    doConv(2, 2, 0, 0, "R6", lat);
    doConv(2, 3, 1, 1, "R6", lat);
    pulseSig(4);
    setAna(21);
    doConv(2, 2, 0, 0, "R9", lat);
    doConv(2, 3, 1, 1, "R9", lat);
  endtask

  task automatic tAlt();
    int lat;
    setAna(5);
    configure(1, 1, 1, 1, 16'h000C, 0, 9, 5, 0);
    doConv(1, 2, 0, 0, "R7", lat);
    doConv(1, 9, 1, 0, "R7", lat);
    doConv(1, 3, 2, 0, "R7", lat);
    doConv(1, 9, 3, 0, "R7", lat);
    doConv(1, 2, 4, 0, "R7", lat);
    doConv(1, 9, 5, 1, "R7", lat);
    pulseSig(4);
    doConv(1, 2, 0, 0, "R9", lat);
  endtask

  task automatic tEmptyMask();
    int lat;
    setAna(7);
    configure(1, 0, 1, 0, 16'h0000, 6, 0, 1, 0);
    doConv(0, 0, 0, 0, "R6", lat);
    doConv(0, 0, 1, 1, "R6", lat);
  endtask

  task automatic tDual();
    int lat;
    setAna(13);
    configure(1, 2, 0, 0, 16'h0000, 7, 0, 9, 1);
    doConv(2, 7, 0, 0, "R10", lat);
    chkEq("R10", "halfSel before irq", int'(halfSel), 0);
    doConv(2, 7, 1, 1, "R10", lat);
    chkEq("R10", "halfSel after first irq", int'(halfSel), 1);
    pulseSig(4);
    setAna(50);
    doConv(2, 7, 8, 0, "R10", lat);
    doConv(2, 7, 9, 1, "R10", lat);
    chkEq("R10", "halfSel after second irq", int'(halfSel), 0);
    pulseSig(4);
    setAna(90);
    doConv(2, 7, 0, 0, "R10", lat);
    rdAddr = 4'd9;
    #1;
    salt = 50;
    chkEq("R10", "upper half kept", int'(rdData), aval(7));
  endtask

  task automatic tAbort();
    int lat;
    int stray;
    setAna(17);
    configure(1, 0, 1, 0, 16'h001C, 0, 0, 15, 0);
    doConv(0, 2, 0, 0, "R12", lat);
    doConv(0, 3, 1, 0, "R12", lat);
    pulseSig(0);
    chkEq("R12", "converting before abort", int'(converting), 1);
    enable = 0;
    @(negedge clk);
    chkEq("R12", "sampling after abort", int'(sampling), 0);
    chkEq("R12", "converting after abort", int'(converting), 0);
    stray = 0;
    for (int i = 0; i < LAT + 3; i++) begin
      @(negedge clk);
      if (convDone) stray++;
    end
    chkEq("R12", "no convDone after abort", stray, 0);
    setAna(33);
    enable = 1;
    doConv(0, 2, 0, 0, "R12", lat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tManual();
    tScanAuto();
    tAlt();
    tEmptyMask();
    tDual();
    tAbort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule